// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose pin controller. Its pins are grouped into banks of up to 32, and each bank carries seven registers: a synchronized level view of the pads, a direction mask, two write-only ports that raise or lower bits of the output latch, two edge-enable masks (one for rising and one for falling transitions) and a sticky edge-status word. Software reaches every register through a plain synchronous bus made of an address, a write strobe, write data and combinational read data. On the pad side, each pin has an input, an output and an output-enable.

Pad inputs pass through a two-flop synchronizer. Each cycle the synchronized value is compared with its copy from the previous cycle. A transition that is enabled sets the matching status bit. The bit stays set until software writes a 1 to it. A single interrupt line reports whether any status bit in any bank is pending. The last bank may be narrower than 32 pins, and its missing bits behave as constant zero.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, the direction, output latch, both edge-enable masks and status are all 0, so `pad_oe`, `pad_out` and `irq` are 0.
- R2: Register kind k (level=0, direction=1, set=2, clear=3, rise-enable=4, fall-enable=5, status=6) of bank b is at byte address G + 4*(b mod 3) + 12*k, with G = 0x000 for banks 0..2 and G = 0x100 for banks 3..5. Direction, rise-enable, fall-enable and status read back their contents. The set and clear ports read as 0. An address that matches no register reads as 0, and a write to it changes nothing.
- R3: A write to a bank's set port drives high every output-latch bit written as 1, on `pad_out` from the next cycle. Bits written as 0 keep their value.
- R4: A write to a bank's clear port drives low every output-latch bit written as 1, on `pad_out` from the next cycle. Bits written as 0 keep their value.
- R5: Direction bit 1 makes a pin an output (`pad_oe` = 1) and 0 makes it an input. `pad_oe` changes only on a write to a direction register.
- R6: The level register returns each pad input after two synchronizer flops: the value on `pad_in` two clock edges earlier.
- R7: A 0-to-1 change of a synchronized input sets its status bit when its rise-enable bit is 1. A 1-to-0 change sets it when its fall-enable bit is 1. Setting both enables catches either edge, and a disabled edge sets nothing.
- R8: Status bits are sticky and write-one-to-clear. Data bits of 0 leave the status unchanged, and writing all ones clears the whole bank.
- R9: When a new edge and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R10: `irq` is 1 exactly when at least one status bit in any bank is 1.
- R11: Bits above the implemented width of the last bank read as 0 in every register and never set status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| pad_out | output | NPINS | Output latch values |
| pad_oe | output | NPINS | Output enables, 1 = drive |
| irq | output | 1 | OR of all status bits |

## Verification
The bound checker enforces four things on every cycle. After a write to the bank-0 set or clear port, the chosen `pad_out` bits must follow on the next cycle. `pad_oe` must hold still unless a direction register is written. A level read of bank 0 must equal the pad value from two edges earlier. The upper bits of every last-bank read must be zero. Behaviours that depend on a sequence of stimulus can only be shown by the bench scenarios: edges captured under each enable, sticky status that survives a zero write, the edge that beats a clearing write in the same cycle, the interrupt raised by a pin in a far bank, and the split address map in both groups.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int BANK_W          = 32;
   localparam int REG_STRIDE      = 12;
   localparam int LANE_STRIDE     = 4;
   localparam int BANKS_PER_GROUP = 3;
   localparam int GROUP_BASE      = 256;
   localparam int MAX_BANKS       = 6;
   localparam int NUM_KINDS       = 7;

   typedef enum logic [2:0] {
      RK_LEVEL = 3'd0,
      RK_DIR   = 3'd1,
      RK_SET   = 3'd2,
      RK_CLR   = 3'd3,
      RK_RISE  = 3'd4,
      RK_FALL  = 3'd5,
      RK_STAT  = 3'd6
   } reg_kind_e;

   function automatic int reg_addr(input int bank, input int kind);
      return ((bank / BANKS_PER_GROUP) * GROUP_BASE)
           + ((bank % BANKS_PER_GROUP) * LANE_STRIDE)
           + (kind * REG_STRIDE);
   endfunction
endpackage

// File: rtl/pinbank_addr_dec.sv
module pinbank_addr_dec
   import pinbank_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int NUM_BANKS = 6,
   parameter int BIDX_W    = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [BIDX_W-1:0] bank_idx,
   output reg_kind_e         kind
);
   logic hi_zero;

   generate
      if (ADDR_W > 9) begin : g_hi
         assign hi_zero = ~|addr[ADDR_W-1:9];
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      int word;
      int kind_i;
      int lane;
      int bank_i;
      word   = int'(addr[7:2]);
      kind_i = word / BANKS_PER_GROUP;
      lane   = word % BANKS_PER_GROUP;
      bank_i = (addr[8] ? BANKS_PER_GROUP : 0) + lane;
      hit    = hi_zero && (addr[1:0] == 2'b00)
               && (kind_i < NUM_KINDS) && (bank_i < NUM_BANKS);
      bank_idx = BIDX_W'(bank_i);
      kind     = reg_kind_e'(kind_i[2:0]);
   end
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
   import pinbank_pkg::*;
#(
   parameter int PINS        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] pin_in,
   input  logic            wr,
   input  reg_kind_e       kind,
   input  logic [PINS-1:0] wdata,
   output logic [31:0]     rdata,
   output logic [PINS-1:0] pin_out,
   output logic [PINS-1:0] pin_oe,
   output logic [PINS-1:0] stat
);
   logic [PINS-1:0] sync_v;
   logic [PINS-1:0] prev_q;
   logic [PINS-1:0] out_q;
   logic [PINS-1:0] dir_q;
   logic [PINS-1:0] rise_q;
   logic [PINS-1:0] fall_q;
   logic [PINS-1:0] stat_q;
   logic [PINS-1:0] edge_hit;
   logic [PINS-1:0] clr_m;

   pinbank_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (sync_v)
   );

   assign edge_hit = (sync_v & ~prev_q & rise_q) | (~sync_v & prev_q & fall_q);
   assign clr_m    = (wr && kind == RK_STAT) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         out_q  <= '0;
         dir_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= sync_v;
         stat_q <= (stat_q & ~clr_m) | edge_hit;
         if (wr) begin
            case (kind)
               RK_DIR:  dir_q  <= wdata;
               RK_SET:  out_q  <= out_q | wdata;
               RK_CLR:  out_q  <= out_q & ~wdata;
               RK_RISE: rise_q <= wdata;
               RK_FALL: fall_q <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (kind)
         RK_LEVEL: rdata = 32'(sync_v);
         RK_DIR:   rdata = 32'(dir_q);
         RK_RISE:  rdata = 32'(rise_q);
         RK_FALL:  rdata = 32'(fall_q);
         RK_STAT:  rdata = 32'(stat_q);
         default:  rdata = '0;
      endcase
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
   assign stat    = stat_q;
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
   import pinbank_pkg::*;
#(
   parameter int NUM_BANKS      = 6,
   parameter int LAST_BANK_PINS = 20,
   parameter int ADDR_W         = 9,
   parameter int SYNC_STAGES    = 2,
   localparam int NPINS         = (NUM_BANKS - 1) * BANK_W + LAST_BANK_PINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq
);
   localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
         $error("pinbank_ctrl: NUM_BANKS must be 1..6");
      end
      if (LAST_BANK_PINS < 1 || LAST_BANK_PINS > BANK_W) begin : g_bad_last
         $error("pinbank_ctrl: LAST_BANK_PINS must be 1..32");
      end
      if (ADDR_W < 9) begin : g_bad_addr
         $error("pinbank_ctrl: ADDR_W must be at least 9");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pinbank_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              hit;
   logic [BIDX_W-1:0] bank_idx;
   reg_kind_e         kind;
   logic [31:0]       bank_rd [NUM_BANKS];
   logic [NPINS-1:0]  stat_all;

   pinbank_addr_dec #(
      .ADDR_W   (ADDR_W),
      .NUM_BANKS(NUM_BANKS),
      .BIDX_W   (BIDX_W)
   ) u_dec (
      .addr    (bus_addr),
      .hit     (hit),
      .bank_idx(bank_idx),
      .kind    (kind)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam int W = (b == NUM_BANKS - 1) ? LAST_BANK_PINS : BANK_W;
         logic wr_sel;
         assign wr_sel = bus_wr && hit && (bank_idx == BIDX_W'(b));
         pinbank_bank #(.PINS(W), .SYNC_STAGES(SYNC_STAGES)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_in (pad_in[b*BANK_W +: W]),
            .wr     (wr_sel),
            .kind   (kind),
            .wdata  (bus_wdata[W-1:0]),
            .rdata  (bank_rd[b]),
            .pin_out(pad_out[b*BANK_W +: W]),
            .pin_oe (pad_oe[b*BANK_W +: W]),
            .stat   (stat_all[b*BANK_W +: W])
         );
      end
   endgenerate

   assign bus_rdata = hit ? bank_rd[bank_idx] : '0;
   assign irq       = |stat_all;
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
   import pinbank_pkg::*;
#(
   parameter int NUM_BANKS      = 6,
   parameter int LAST_BANK_PINS = 20,
   parameter int ADDR_W         = 9,
   parameter int SYNC_STAGES    = 2,
   parameter int NPINS          = 180
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [NPINS-1:0]  pad_in,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_oe
);
   localparam int W0 = (NUM_BANKS == 1) ? LAST_BANK_PINS : BANK_W;
   localparam int LB = NUM_BANKS - 1;

   logic [1:0] cyc;
   logic       is_dir;
   logic       is_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   always_comb begin
      is_dir  = 1'b0;
      is_last = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (int'(bus_addr) == reg_addr(b, 1)) is_dir = 1'b1;
      for (int k = 0; k < NUM_KINDS; k++)
         if (int'(bus_addr) == reg_addr(LB, k)) is_last = 1'b1;
   end

   // R3: set port of bank 0 raises the written bits on the next cycle
   a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && int'(bus_addr) == reg_addr(0, 2))
      |=> ((pad_out[W0-1:0] & $past(bus_wdata[W0-1:0])) == $past(bus_wdata[W0-1:0])));

   // R4: clear port of bank 0 lowers the written bits on the next cycle
   a_r4_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && int'(bus_addr) == reg_addr(0, 3))
      |=> ((pad_out[W0-1:0] & $past(bus_wdata[W0-1:0])) == '0));

   // R5: output enables move only on a direction write
   a_r5_oe_only_by_dir: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && is_dir) |=> $stable(pad_oe));

   generate
      if (SYNC_STAGES == 2) begin : g_lvl
         // R6: level view of bank 0 lags the pads by two edges
         a_r6_level_lag: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc == 2'd3 && int'(bus_addr) == reg_addr(0, 0))
            |-> (bus_rdata[W0-1:0] == $past(pad_in[W0-1:0], 2)));
      end
      if (LAST_BANK_PINS < BANK_W) begin : g_narrow
         // R11: absent pins of the last bank always read 0
         a_r11_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
            is_last |-> (bus_rdata[31:LAST_BANK_PINS] == '0));
      end
   endgenerate
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
   .NUM_BANKS     (NUM_BANKS),
   .LAST_BANK_PINS(LAST_BANK_PINS),
   .ADDR_W        (ADDR_W),
   .SYNC_STAGES   (SYNC_STAGES),
   .NPINS         (NPINS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .pad_in   (pad_in),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe)
);

// File: tb/pinbank_ctrl_bench.sv
`timescale 1ns/1ps
module pinbank_ctrl_bench;
   localparam int NPINS = 180;
   localparam int NV    = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NPINS-1:0] pad_in = '0;
   logic [NPINS-1:0] pad_out;
   logic [NPINS-1:0] pad_oe;
   logic        irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   pinbank_ctrl u_pinbank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   // {is_read, tag (0 = R2, 1 = R11), addr, data}
   localparam logic [42:0] VECS [NV] = '{
      {1'b0, 1'b0, 9'h00C, 32'hFFFF0000},  // R2 bank0 direction
      {1'b1, 1'b0, 9'h00C, 32'hFFFF0000},
      {1'b0, 1'b0, 9'h134, 32'hA5A5A5A5},  // R2 bank4 rise enable
      {1'b1, 1'b0, 9'h134, 32'hA5A5A5A5},
      {1'b0, 1'b1, 9'h144, 32'hFFFFFFFF},  // R11 bank5 fall enable, 20 pins
      {1'b1, 1'b1, 9'h144, 32'h000FFFFF},
      {1'b0, 1'b0, 9'h038, 32'h00000001},  // R2 bank2 rise enable
      {1'b1, 1'b0, 9'h038, 32'h00000001},
      {1'b1, 1'b0, 9'h03C, 32'h00000000},  // R2 bank0 fall untouched
      {1'b0, 1'b0, 9'h054, 32'hFFFFFFFF},  // R2 unmapped write
      {1'b1, 1'b0, 9'h054, 32'h00000000},
      {1'b1, 1'b0, 9'h018, 32'h00000000},  // R2 set port reads 0
      {1'b1, 1'b0, 9'h00C, 32'hFFFF0000}
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      #1;
      check(bus_rdata == exp, req, 64'(bus_rdata), 64'(exp));
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      // R1 reset state
      check(pad_oe == '0, "R1 pad_oe", 64'(pad_oe[31:0]), 0);
      check(pad_out == '0, "R1 pad_out", 64'(pad_out[31:0]), 0);
      check(irq == 1'b0, "R1 irq", 64'(irq), 0);
      rd(9'h10C, 32'h0, "R1 bank3 direction");

      for (int i = 0; i < NV; i++) begin
         if (VECS[i][42]) rd(VECS[i][40:32], VECS[i][31:0], VECS[i][41] ? "R11 table" : "R2 table");
         else wr(VECS[i][40:32], VECS[i][31:0]);
      end

      // R3 / R4 set and clear ports
      wr(9'h018, 32'h000000F0);
      check(pad_out[31:0] == 32'hF0, "R3 set", 64'(pad_out[31:0]), 64'hF0);
      wr(9'h024, 32'h00000030);
      check(pad_out[31:0] == 32'hC0, "R4 clear", 64'(pad_out[31:0]), 64'hC0);
      wr(9'h018, 32'h0);
      check(pad_out[31:0] == 32'hC0, "R3 zero bits", 64'(pad_out[31:0]), 64'hC0);
      wr(9'h118, 32'h1);
      check(pad_out[96] == 1'b1, "R3 bank3 set", 64'(pad_out[96]), 1);
      // R5 direction
      check(pad_oe[31:0] == 32'hFFFF0000 && pad_oe[179:32] == '0, "R5 oe",
            64'(pad_oe[31:0]), 64'hFFFF0000);

      // R6 level with two-edge lag
      pad_in[40] = 1'b1;
      wait_n(4);
      rd(9'h004, 32'h100, "R6 level");
      pad_in[41] = 1'b1;
      wait_n(1);
      rd(9'h004, 32'h100, "R6 lag");
      wait_n(1);
      rd(9'h004, 32'h300, "R6 settled");

      // R7 / R8 / R10 edge capture
      wr(9'h030, 32'h5);
      wr(9'h03C, 32'h4);
      pad_in[0] = 1'b1;
      wait_n(4);
      rd(9'h048, 32'h1, "R7 rise");
      check(irq == 1'b1, "R10 irq set", 64'(irq), 1);
      pad_in[0] = 1'b0;
      wait_n(4);
      rd(9'h048, 32'h1, "R7 fall disabled");
      wr(9'h048, 32'h0);
      rd(9'h048, 32'h1, "R8 zero write");
      wr(9'h048, 32'h1);
      rd(9'h048, 32'h0, "R8 w1c");
      check(irq == 1'b0, "R10 irq clear", 64'(irq), 0);
      pad_in[2] = 1'b1;
      wait_n(4);
      rd(9'h048, 32'h4, "R7 both rise");
      wr(9'h048, 32'h4);
      pad_in[2] = 1'b0;
      wait_n(4);
      rd(9'h048, 32'h4, "R7 both fall");
      wr(9'h048, 32'hFFFFFFFF);
      rd(9'h048, 32'h0, "R8 clear all");

      // R9 edge and clear in the same cycle
      @(negedge clk);
      pad_in[2] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_addr = 9'h048; bus_wdata = 32'h4; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(9'h048, 32'h4, "R9 edge wins");
      wr(9'h048, 32'hFFFFFFFF);

      // R11 / R10 narrow last bank
      pad_in[179] = 1'b1;
      wait_n(4);
      pad_in[179] = 1'b0;
      wait_n(4);
      rd(9'h150, 32'h00080000, "R11 last bank status");
      check(irq == 1'b1, "R10 far bank irq", 64'(irq), 1);
      wr(9'h150, 32'hFFFFFFFF);
      rd(9'h150, 32'h0, "R11 cleared");
      check(irq == 1'b0, "R10 irq idle", 64'(irq), 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule